// File: doc/BRIEF.md
# Toeplitz Receive Queue Selector

This block assigns an incoming packet to a receive queue by flow. It takes header fields that an upstream parser has already pulled out: the IP version, both addresses, both ports, a flag saying whether the transport protocol carries ports, the IPv4 more-fragments bit, the fragment offset and the IPv6 flow label. From these it builds an input byte string and hashes that string with a Toeplitz hash under a secret key that the host programs. The hash modulo a host-set table length picks an entry of an indirection table. That entry is the queue ID.

The packet is accepted with a valid/ready handshake. One input byte is hashed per clock cycle. The 32-bit hash and the queue ID then leave through a second valid/ready handshake, so the hash can travel to the host with the packet. A simple word-wide register port reads and writes the key and the table at any time. The block takes a snapshot of the key when it accepts a packet, so later key writes do not change a hash already under way.

Top module: `rss_queue_select`

## Requirements
- R1: An unfragmented packet with `in_has_ports`=1 hashes the bytes source address, destination address, source port, destination port, each big-endian. An IPv4 packet uses `in_*_addr[31:0]`, which gives 12 bytes. An IPv6 packet uses all 128 bits, which gives 36 bytes. With `in_has_ports`=0 the ports are dropped, giving 8 or 32 bytes.
- R2: An IPv4 packet with `in_more_frag`=1 or a non-zero `in_frag_off` hashes only its two addresses, even with `in_has_ports`=1. On IPv6 packets both fragment inputs have no effect.
- R3: With `cfg_flow_label_en`=1, an IPv6 packet's byte string begins with 4 extra bytes: 12 zero bits, then the 20-bit flow label. IPv4 packets ignore this control.
- R4: Key bit j is bit 7-(j mod 8) of key byte j/8. For each set bit at stream position i, the hash is XORed with key bits i..i+31, where key bit i is the hash MSB. A stream bit at position i is bit 7-(i mod 8) of byte i/8. Positions start from key bit 0 for every packet.
- R5: `out_queue` is table entry (hash mod L). L is `cfg_tbl_len`, clamped to TBL_DEPTH. If L is 0, entry 0 is used.
- R6: The first `out_valid` comes N+1 clock edges after the accepting edge, where N is the byte count. `in_ready` is high only when no packet is held in the block.
- R7: While `out_valid`=1 and `out_ready`=0, the outputs keep their values. An edge with both high empties the block and raises `in_ready`.
- R8: With `reg_tbl`=0, word w of the key holds key bytes 4w..4w+3, with byte 4w in bits 31:24. With `reg_tbl`=1, address a is table entry a, held in the low QID_W bits. Reads are combinational, and an address past the end reads 0.
- R9: A key write made after a packet was accepted leaves that packet's hash unchanged and applies to the next packet. A table write made between two packets applies to the second.
- R10: After reset, the key and the table are all zero, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Header fields are valid |
| in_ready | output | 1 | Block can accept a packet |
| in_ipv6 | input | 1 | 1 = IPv6, 0 = IPv4 |
| in_src_addr | input | 128 | Source address (IPv4 in bits 31:0) |
| in_dst_addr | input | 128 | Destination address (IPv4 in bits 31:0) |
| in_src_port | input | 16 | Source port |
| in_dst_port | input | 16 | Destination port |
| in_has_ports | input | 1 | Transport protocol carries ports |
| in_more_frag | input | 1 | IPv4 more-fragments bit |
| in_frag_off | input | 13 | IPv4 fragment offset |
| in_flow_label | input | 20 | IPv6 flow label |
| cfg_flow_label_en | input | 1 | Put the flow label before the addresses |
| cfg_tbl_len | input | $clog2(TBL_DEPTH)+1 | Indirection table length used |
| reg_we | input | 1 | Register write strobe |
| reg_tbl | input | 1 | 0 = key space, 1 = table space |
| reg_addr | input | RA_W | Word or entry address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_hash | output | 32 | Toeplitz hash |
| out_queue | output | QID_W | Selected queue ID |

## Verification
The checker assumes that the downstream side may hold `out_ready` low for any number of cycles. It also assumes that a packet is always at least 8 bytes long, so `in_ready` never rises on the edge right after acceptance. The bench keeps the header fields constant between acceptance and the end of the packet. It changes the key only through the register port and keeps `cfg_tbl_len` fixed while a packet is in flight. The bench sweeps every table length from 0 to past the table depth, combined with each tuple shape.

// File: rtl/rss_queue_select.sv
`timescale 1ns/1ps
module rss_queue_select #(
  parameter int KEY_BYTES = 44,
  parameter int TBL_DEPTH = 16,
  parameter int QID_W = 6,
  localparam int KEY_WORDS = (KEY_BYTES + 3) / 4,
  localparam int TI_W = $clog2(TBL_DEPTH),
  localparam int KW_W = $clog2(KEY_WORDS),
  localparam int RA_W = (KW_W > TI_W) ? KW_W : TI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ipv6,
  input  logic [127:0]      in_src_addr,
  input  logic [127:0]      in_dst_addr,
  input  logic [15:0]       in_src_port,
  input  logic [15:0]       in_dst_port,
  input  logic              in_has_ports,
  input  logic              in_more_frag,
  input  logic [12:0]       in_frag_off,
  input  logic [19:0]       in_flow_label,
  input  logic              cfg_flow_label_en,
  input  logic [TI_W:0]     cfg_tbl_len,
  input  logic              reg_we,
  input  logic              reg_tbl,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_hash,
  output logic [QID_W-1:0]  out_queue
);
  localparam int KEY_BITS = KEY_WORDS * 32;
  localparam int MSG_BITS = 320;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_LOOK, S_OUT} state_t;

  state_t              st;
  logic [MSG_BITS-1:0] msg, msg_in;
  logic [KEY_BITS-1:0] key_sh, key_flat;
  logic [5:0]          cnt, len_in;
  logic [31:0]         hash, step, rem, addr32, len32;
  logic [QID_W-1:0]    q;
  logic [31:0]         key_mem [KEY_WORDS];
  logic [QID_W-1:0]    tbl [TBL_DEPTH];
  logic                frag, four;

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_key
    assign key_flat[KEY_BITS-1-32*w -: 32] = key_mem[w];
  end

  assign frag = !in_ipv6 && (in_more_frag || in_frag_off != 13'd0);
  assign four = in_has_ports && !frag;

  always_comb begin
    if (!in_ipv6) begin
      msg_in = {in_src_addr[31:0], in_dst_addr[31:0], in_src_port, in_dst_port, 224'd0};
      len_in = four ? 6'd12 : 6'd8;
    end else if (cfg_flow_label_en) begin
      msg_in = {12'd0, in_flow_label, in_src_addr, in_dst_addr, in_src_port, in_dst_port};
      len_in = four ? 6'd40 : 6'd36;
    end else begin
      msg_in = {in_src_addr, in_dst_addr, in_src_port, in_dst_port, 32'd0};
      len_in = four ? 6'd36 : 6'd32;
    end
  end

  always_comb begin
    step = hash;
    for (int b = 0; b < 8; b++)
      if (msg[MSG_BITS-1-b]) step = step ^ key_sh[KEY_BITS-1-b -: 32];
  end

  assign len32 = (32'(cfg_tbl_len) > TBL_DEPTH) ? TBL_DEPTH : 32'(cfg_tbl_len);
  assign rem   = (len32 == 32'd0) ? 32'd0 : hash % len32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      msg <= '0;
      key_sh <= '0;
      cnt <= '0;
      hash <= '0;
      q <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          msg <= msg_in;
          key_sh <= key_flat;
          cnt <= len_in;
          hash <= '0;
          st <= S_HASH;
        end
        S_HASH: begin
          hash <= step;
          msg <= msg << 8;
          key_sh <= key_sh << 8;
          cnt <= cnt - 6'd1;
          if (cnt == 6'd1) st <= S_LOOK;
        end
        S_LOOK: begin
          q <= tbl[rem[TI_W-1:0]];
          st <= S_OUT;
        end
        default: if (out_ready) st <= S_IDLE;
      endcase
    end
  end

  assign addr32 = 32'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) key_mem[i] <= '0;
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
    end else if (reg_we) begin
      if (reg_tbl && addr32 < TBL_DEPTH) tbl[reg_addr[TI_W-1:0]] <= reg_wdata[QID_W-1:0];
      if (!reg_tbl && addr32 < KEY_WORDS) key_mem[reg_addr[KW_W-1:0]] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_tbl && addr32 < TBL_DEPTH) reg_rdata = 32'(tbl[reg_addr[TI_W-1:0]]);
    if (!reg_tbl && addr32 < KEY_WORDS) reg_rdata = key_mem[reg_addr[KW_W-1:0]];
  end

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_OUT);
  assign out_hash  = hash;
  assign out_queue = q;
endmodule

// File: rtl/rss_sel_chk.sv
`timescale 1ns/1ps
module rss_sel_chk #(parameter int QID_W = 6) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_hash,
  input logic [QID_W-1:0] out_queue
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hash) && $stable(out_queue));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);
endmodule

bind rss_queue_select rss_sel_chk #(.QID_W(QID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hash(out_hash), .out_queue(out_queue)
);

// File: tb/tb_rss_queue_select.sv
`timescale 1ns/1ps
module tb_rss_queue_select;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic in_valid = 0, t_v6 = 0, t_hp = 0, t_mf = 0, t_fle = 0;
  logic [127:0] t_src = 0, t_dst = 0;
  logic [15:0] t_sp = 0, t_dp = 0;
  logic [12:0] t_fo = 0;
  logic [19:0] t_fl = 0;
  logic [4:0] t_len = 0;
  logic reg_we = 0, reg_tbl = 0, out_ready = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic in_ready, out_valid;
  logic [31:0] reg_rdata, out_hash;
  logic [5:0] out_queue;

  rss_queue_select dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ipv6(t_v6), .in_src_addr(t_src), .in_dst_addr(t_dst),
    .in_src_port(t_sp), .in_dst_port(t_dp), .in_has_ports(t_hp),
    .in_more_frag(t_mf), .in_frag_off(t_fo), .in_flow_label(t_fl),
    .cfg_flow_label_en(t_fle), .cfg_tbl_len(t_len),
    .reg_we(reg_we), .reg_tbl(reg_tbl), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hash(out_hash), .out_queue(out_queue)
  );

  int checks = 0, errors = 0;
  byte unsigned kb [44];
  logic [5:0] tm [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] win(input int i);
    logic [31:0] w;
    for (int t = 0; t < 32; t++) w[31-t] = kb[(i+t)/8][7-((i+t)%8)];
    return w;
  endfunction

  function automatic logic [31:0] ref_hash(output int n);
    byte unsigned s[$];
    int nb;
    bit frag, four;
    logic [31:0] h = 0;
    logic [31:0] flw;
    frag = !t_v6 && (t_mf || t_fo != 0);
    four = t_hp && !frag;
    nb = t_v6 ? 16 : 4;
    if (t_v6 && t_fle) begin
      flw = {12'd0, t_fl};
      for (int i = 0; i < 4; i++) s.push_back(flw[31-8*i -: 8]);
    end
    for (int i = 0; i < nb; i++) s.push_back(t_src[8*nb-1-8*i -: 8]);
    for (int i = 0; i < nb; i++) s.push_back(t_dst[8*nb-1-8*i -: 8]);
    if (four) begin
      s.push_back(t_sp[15:8]); s.push_back(t_sp[7:0]);
      s.push_back(t_dp[15:8]); s.push_back(t_dp[7:0]);
    end
    n = s.size();
    for (int i = 0; i < 8*n; i++) if (s[i/8][7-(i%8)]) h ^= win(i);
    return h;
  endfunction

  function automatic logic [5:0] ref_q(input logic [31:0] h);
    int l = (t_len > 16) ? 16 : t_len;
    return (l == 0) ? tm[0] : tm[h % l];
  endfunction

  task automatic wr(input bit tsel, input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_tbl = tsel; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input bit tsel, input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_tbl = tsel; reg_addr = 4'(a);
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic launch();
    @(negedge clk);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic collect(input string tag, input logic [31:0] eh, input logic [5:0] eq,
                         input int n, input int k0, input int hold);
    int k = k0;
    while (!out_valid && k < 200) begin @(negedge clk); k++; end
    chk(k == n + 1, {"R6 latency ", tag}, k, n + 1);
    chk(out_hash == eh, {"R4 hash ", tag}, out_hash, eh);
    chk(out_queue == eq, {"R5 queue ", tag}, out_queue, eq);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && !in_ready && out_hash == eh && out_queue == eq,
          {"R7 hold ", tag}, out_hash, eh);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && in_ready, {"R7 drain ", tag}, {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  task automatic run(input string tag, input int hold);
    int n;
    logic [31:0] eh;
    eh = ref_hash(n);
    launch();
    collect(tag, eh, ref_q(eh), n, 0, hold);
  endtask

  task automatic rand_pkt(input int mode);
    t_v6 = mode[0];
    t_src = {$urandom, $urandom, $urandom, $urandom};
    t_dst = {$urandom, $urandom, $urandom, $urandom};
    t_sp = 16'($urandom); t_dp = 16'($urandom);
    t_hp = mode[1];
    t_mf = mode[2];
    t_fo = mode[3] ? 13'($urandom | 1) : 13'd0;
    t_fle = mode[4];
    t_fl = 20'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    static byte unsigned std_key [40] = '{
      8'h6d,8'h5a,8'h56,8'hda,8'h25,8'h5b,8'h0e,8'hc2,8'h41,8'h67,
      8'h25,8'h3d,8'h43,8'ha3,8'h8f,8'hb0,8'hd0,8'hca,8'h2b,8'hcb,
      8'hae,8'h7b,8'h30,8'hb4,8'h77,8'hcb,8'h2d,8'ha3,8'h80,8'h30,
      8'hf2,8'h0c,8'h6a,8'h42,8'hb7,8'h3b,8'hbe,8'hac,8'h01,8'hfa};
    logic [31:0] eh0;
    int n0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R10 idle after reset", {30'd0, in_ready, out_valid}, 32'd2);
    rd(0, 3, 32'd0, "R10 key cleared");
    rd(1, 7, 32'd0, "R10 table cleared");

    for (int i = 0; i < 40; i++) kb[i] = std_key[i];
    kb[40] = 8'h5a; kb[41] = 8'h13; kb[42] = 8'hc7; kb[43] = 8'h88;
    for (int w = 0; w < 11; w++) wr(0, w, {kb[4*w], kb[4*w+1], kb[4*w+2], kb[4*w+3]});
    for (int i = 0; i < 16; i++) begin
      tm[i] = 6'((i * 7 + 3) % 64);
      wr(1, i, 32'hffff_ff00 | 32'(tm[i]));
    end
    rd(0, 0, 32'h6d5a56da, "R8 key word 0 readback");
    rd(0, 10, 32'h5a13c788, "R8 key word 10 readback");
    rd(1, 5, 32'(tm[5]), "R8 table entry keeps low bits");
    rd(0, 12, 32'd0, "R8 key address past end");

    t_len = 5'd16;
    t_v6 = 0; t_src = 128'h420995bb; t_dst = 128'ha18e6450;
    t_sp = 16'd2794; t_dp = 16'd1766; t_hp = 1; t_mf = 0; t_fo = 0; t_fle = 0; t_fl = 20'habcde;
    launch();
    collect("R1 ipv4 4-tuple vector", 32'h51ccc178, ref_q(32'h51ccc178), 12, 0, 0);
    t_fle = 1;
    launch();
    collect("R3 ipv4 ignores label", 32'h51ccc178, ref_q(32'h51ccc178), 12, 0, 0);
    t_fle = 0; t_hp = 0;
    launch();
    collect("R1 ipv4 2-tuple vector", 32'h323e8fc2, ref_q(32'h323e8fc2), 8, 0, 0);
    t_hp = 1; t_mf = 1;
    launch();
    collect("R2 more-frag drops ports", 32'h323e8fc2, ref_q(32'h323e8fc2), 8, 0, 0);
    t_mf = 0; t_fo = 13'd185;
    launch();
    collect("R2 offset drops ports", 32'h323e8fc2, ref_q(32'h323e8fc2), 8, 0, 3);
    t_fo = 0;

    rand_pkt(5'b00111); run("R2 ipv6 ignores frag", 0);
    rand_pkt(5'b11011); run("R3 ipv6 label 4-tuple", 0);
    rand_pkt(5'b10001); run("R3 ipv6 label 2-tuple", 2);

    for (int l = 0; l <= 18; l++) begin
      t_len = 5'(l);
      for (int m = 0; m < 6; m++) begin
        rand_pkt((m * 11 + l) % 32);
        run("R5 sweep", m % 2);
      end
    end

    t_len = 5'd16;
    rand_pkt(5'b00011);
    eh0 = ref_hash(n0);
    launch();
    reg_we = 1; reg_tbl = 0; reg_addr = 4'd0; reg_wdata = 32'h0123abcd;
    @(negedge clk);
    reg_we = 0;
    collect("R9 key write mid-hash", eh0, ref_q(eh0), n0, 1, 0);
    kb[0] = 8'h01; kb[1] = 8'h23; kb[2] = 8'hab; kb[3] = 8'hcd;
    run("R9 new key next packet", 0);

    t_len = 5'd1;
    run("R5 len one", 0);
    tm[0] = 6'h2a;
    wr(1, 0, 32'h2a);
    run("R9 table write between packets", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule